// File: doc/BRIEF.md
# Banked Cartridge Mapper with Pattern-RAM Routing

This block sits between a CPU bus and a picture-processor bus inside a game cartridge. CPU writes anywhere in $8000–$FFFF go to a set of bank registers, and the address lines that pick the register within a group are CPU A3 and A2. Two of these registers choose which 8 KiB program banks appear in the lower two program windows. The upper two windows are fixed to the last two banks. A third register holds the nametable mirroring mode. The remaining registers are eight pattern-table slot selectors, one for each 1 KiB of picture-processor space. The block also holds 8 KiB of work RAM at CPU $6000–$7FFF.

For each picture-processor access, the slot selector picks the backing store. Selector values 6 and 7 send the access to one of two internal 1 KiB writable pages. Every other value sends it to an external read-only pattern store, addressed by the selector followed by the 10-bit slot offset.

A small read state machine delivers pattern data one cycle after the request, whichever source serves it. It has three states:
- `P_IDLE`: no read was issued in the previous cycle.
- `P_ROM_RD`: a read was routed to the pattern store in the previous cycle.
- `P_RAM_RD`: a read was routed to an internal page in the previous cycle.

Every state follows the same transitions:
- A read to a RAM-routed slot moves to `P_RAM_RD`.
- A read to a ROM-routed slot moves to `P_ROM_RD`.
- No read moves to `P_IDLE`.

Top module: `cart_bank_mapper`

## Requirements
- R1: The register group is CPU A15–A12 and the register index is {A3,A2}. CPU A1, A0 and A11–A4 play no part in register selection. Writes to the $F000 group change nothing.
- R2: A CPU write in $6000–$7FFF stores the byte in work RAM at offset A12–A0. A CPU read there returns the stored byte on `cpu_rdata` one cycle later. In every other cycle `cpu_rdata` is 0.
- R3: A write to the $8000 group sets the bank for $8000–$9FFF to data[4:0]. A write to the $A000 group sets the bank for $A000–$BFFF to data[4:0]. $C000–$DFFF is fixed to bank 30 and $E000–$FFFF to bank 31. `prg_rom_addr` = {bank, A12–A0}.
- R4: The groups $B000, $C000, $D000 and $E000 hold the slot selectors. The slot is 2×(group−$B)+A3. With A2=0 the write sets selector bits 3:0 from data[3:0]. With A2=1 it sets selector bits 8:4 from data[4:0].
- R5: An access whose slot selector equals exactly 6 or 7 is routed to internal RAM. Every other value, including 0x16, is routed to the pattern store. `chr_rom_re` is high only for reads routed to the store.
- R6: `chr_rom_addr` = {selector of slot ppu_addr[12:10], ppu_addr[9:0]}.
- R7: `ppu_rdata` carries read data one cycle after `ppu_re`, from the store or from internal RAM. It is 0 in a cycle that follows no read.
- R8: Pattern writes to a store-routed slot are dropped. Internal RAM is indexed by (selector−6)×1024 + ppu_addr[9:0], so the two pages hold independent data.
- R9: A write to the $9000 group with index 0 sets `mirror` to data[1:0], where 0 means vertical. The other indices of that group are ignored.
- R10: After reset, `mirror` is vertical, both switchable program banks are 0, all slot selectors are 0 and `ppu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Work RAM read data, one cycle after the read |
| prg_rom_addr | output | 18 | Program store address for CPU $8000–$FFFF |
| ppu_addr | input | 13 | Picture-processor pattern address |
| ppu_wdata | input | 8 | Pattern write data |
| ppu_we | input | 1 | Pattern write strobe |
| ppu_re | input | 1 | Pattern read strobe |
| ppu_rdata | output | 8 | Pattern read data, one cycle after the read |
| chr_rom_addr | output | 19 | Pattern store address |
| chr_rom_re | output | 1 | Pattern store read enable |
| chr_rom_data | input | 8 | Pattern store data, one cycle after its address |
| mirror | output | 2 | Nametable mirroring mode |

## Verification
The bench first sets a selector to 0x16. A design that compares only the low nibble against 6 would serve that slot from internal RAM instead of the store. It then writes to a store-routed slot and reads the same offset back through a RAM page. A design that ignores the write gate would corrupt the page. It also writes one page and reads the same offset through the other page, which exposes a design that drops the page bit from the RAM index. Further cases cover a write to $B004 that must land in the high part of slot 0, a write with A1/A0 set that must still decode, mirroring writes at index 1 that must be ignored, and program bank values above 31 that must be truncated.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    localparam int SLOTS      = 8;
    localparam int SLOT_AW    = $clog2(SLOTS);
    localparam int PAGE_AW    = 10;
    localparam int NIB_W      = 4;

    localparam logic [2:0] GRP_PRG_A   = 3'd0;
    localparam logic [2:0] GRP_MIRROR  = 3'd1;
    localparam logic [2:0] GRP_PRG_B   = 3'd2;
    localparam logic [2:0] GRP_SLOT_LO = 3'd3;
    localparam logic [2:0] GRP_SLOT_HI = 3'd6;

    localparam logic [1:0] MIR_VERTICAL = 2'd0;

    typedef enum logic [1:0] {
        P_IDLE   = 2'd0,
        P_ROM_RD = 2'd1,
        P_RAM_RD = 2'd2
    } pat_state_t;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
    import cbm_pkg::*;
#(
    parameter int PRG_BW = 5,
    parameter int SEL_W  = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [2:0]                   grp,
    input  logic [1:0]                   idx,
    input  logic [7:0]                   wdata,
    output logic [PRG_BW-1:0]            prg_a,
    output logic [PRG_BW-1:0]            prg_b,
    output logic [SLOTS-1:0][SEL_W-1:0]  sel,
    output logic [1:0]                   mirror
);
    localparam int HI_W = SEL_W - NIB_W;

    logic               in_slot_grp;
    logic [SLOT_AW-1:0] slot;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;
    assign in_slot_grp  = (grp >= GRP_SLOT_LO) && (grp <= GRP_SLOT_HI);
    // group 3..6 maps to slot pair 0..3; A3 picks the odd slot
    assign slot = {grp[1:0] + 2'd1, idx[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prg_a  <= '0;
            prg_b  <= '0;
            mirror <= MIR_VERTICAL;
        end else if (we) begin
            case (grp)
                GRP_PRG_A:  prg_a <= wdata[PRG_BW-1:0];
                GRP_PRG_B:  prg_b <= wdata[PRG_BW-1:0];
                GRP_MIRROR: if (idx == 2'd0) mirror <= wdata[1:0];
                default:    ;
            endcase
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [NIB_W-1:0] lo_q;
        logic [HI_W-1:0]  hi_q;
        logic             hit;

        assign hit = we && in_slot_grp && (slot == SLOT_AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (hit) begin
                if (idx[0]) hi_q <= wdata[HI_W-1:0];
                else        lo_q <= wdata[NIB_W-1:0];
            end
        end

        assign sel[g] = {hi_q, lo_q};
    end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
    parameter int PRG_BANKS = 32,
    parameter int PRG_BW    = 5
) (
    input  logic [14:0]        addr,
    input  logic [PRG_BW-1:0]  prg_a,
    input  logic [PRG_BW-1:0]  prg_b,
    output logic [PRG_BW+12:0] rom_addr
);
    localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);
    localparam logic [PRG_BW-1:0] PREV_BANK = PRG_BW'(PRG_BANKS - 2);

    logic [PRG_BW-1:0] bank;

    always_comb begin
        unique case (addr[14:13])
            2'd0:    bank = prg_a;
            2'd1:    bank = prg_b;
            2'd2:    bank = PREV_BANK;
            default: bank = LAST_BANK;
        endcase
        rom_addr = {bank, addr[12:0]};
    end
endmodule

// File: rtl/cbm_chr_path.sv
module cbm_chr_path
    import cbm_pkg::*;
#(
    parameter int SEL_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [12:0]                 ppu_addr,
    input  logic [7:0]                  ppu_wdata,
    input  logic                        ppu_we,
    input  logic                        ppu_re,
    input  logic [SLOTS-1:0][SEL_W-1:0] sel,
    input  logic [7:0]                  chr_rom_data,
    output logic [SEL_W+PAGE_AW-1:0]    chr_rom_addr,
    output logic                        chr_rom_re,
    output logic [7:0]                  ppu_rdata
);
    localparam logic [SEL_W-1:0] PAGE0_SEL = SEL_W'(6);
    localparam logic [SEL_W-1:0] PAGE1_SEL = SEL_W'(7);
    localparam int               RAM_DEPTH = 2 << PAGE_AW;

    logic [SEL_W-1:0]   cur_sel;
    logic               to_ram;
    logic [PAGE_AW:0]   ram_idx;
    logic [7:0]         mem [RAM_DEPTH];
    logic [7:0]         ram_q;
    pat_state_t         st, st_nx;

    assign cur_sel      = sel[ppu_addr[12:PAGE_AW]];
    assign to_ram       = (cur_sel == PAGE0_SEL) || (cur_sel == PAGE1_SEL);
    assign ram_idx      = {cur_sel[0], ppu_addr[PAGE_AW-1:0]};
    assign chr_rom_addr = {cur_sel, ppu_addr[PAGE_AW-1:0]};
    assign chr_rom_re   = ppu_re && !to_ram;

    always_ff @(posedge clk) begin
        if (ppu_we && to_ram) mem[ram_idx] <= ppu_wdata;
        if (ppu_re && to_ram) ram_q <= mem[ram_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= P_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            P_IDLE, P_ROM_RD, P_RAM_RD: begin
                if (ppu_re) st_nx = to_ram ? P_RAM_RD : P_ROM_RD;
                else        st_nx = P_IDLE;
            end
            default: st_nx = P_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            P_ROM_RD: ppu_rdata = chr_rom_data;
            P_RAM_RD: ppu_rdata = ram_q;
            default:  ppu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cbm_wram.sv
module cbm_wram #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    logic       rd_v;

    always_ff @(posedge clk) begin
        if (we && hit) mem[addr] <= wdata;
        if (re && hit) q <= mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_v <= 1'b0;
        else        rd_v <= re && hit;
    end

    assign rdata = rd_v ? q : '0;
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter  int PRG_BANKS = 32,
    parameter  int SEL_W     = 9,
    parameter  int WRAM_AW   = 13,
    localparam int PRG_BW    = $clog2(PRG_BANKS),
    localparam int PRG_AW    = PRG_BW + 13,
    localparam int CHR_AW    = SEL_W + PAGE_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_re,
    output logic [7:0]        cpu_rdata,
    output logic [PRG_AW-1:0] prg_rom_addr,
    input  logic [12:0]       ppu_addr,
    input  logic [7:0]        ppu_wdata,
    input  logic              ppu_we,
    input  logic              ppu_re,
    output logic [7:0]        ppu_rdata,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic              chr_rom_re,
    input  logic [7:0]        chr_rom_data,
    output logic [1:0]        mirror
);
    logic [PRG_BW-1:0]           prg_a, prg_b;
    logic [SLOTS-1:0][SEL_W-1:0] sel;
    logic                        wram_hit;

    assign wram_hit = (cpu_addr[15:13] == 3'b011);

    cbm_regs #(.PRG_BW(PRG_BW), .SEL_W(SEL_W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cpu_we && cpu_addr[15]),
        .grp    (cpu_addr[14:12]),
        .idx    (cpu_addr[3:2]),
        .wdata  (cpu_wdata),
        .prg_a  (prg_a),
        .prg_b  (prg_b),
        .sel    (sel),
        .mirror (mirror)
    );

    cbm_prg_map #(.PRG_BANKS(PRG_BANKS), .PRG_BW(PRG_BW)) prg_i (
        .addr     (cpu_addr[14:0]),
        .prg_a    (prg_a),
        .prg_b    (prg_b),
        .rom_addr (prg_rom_addr)
    );

    cbm_chr_path #(.SEL_W(SEL_W)) chr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ppu_addr     (ppu_addr),
        .ppu_wdata    (ppu_wdata),
        .ppu_we       (ppu_we),
        .ppu_re       (ppu_re),
        .sel          (sel),
        .chr_rom_data (chr_rom_data),
        .chr_rom_addr (chr_rom_addr),
        .chr_rom_re   (chr_rom_re),
        .ppu_rdata    (ppu_rdata)
    );

    cbm_wram #(.AW(WRAM_AW)) wram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (wram_hit),
        .we    (cpu_we),
        .re    (cpu_re),
        .addr  (cpu_addr[WRAM_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (cpu_rdata)
    );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
    parameter int PRG_BANKS = 32,
    parameter int SEL_W     = 9
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [2:0]                   cpu_top,
    input logic                         cpu_we,
    input logic                         cpu_re,
    input logic [7:0]                   cpu_rdata,
    input logic [$clog2(PRG_BANKS)-1:0] prg_bank,
    input logic                         ppu_re,
    input logic [7:0]                   ppu_rdata,
    input logic                         chr_rom_re,
    input logic [SEL_W-1:0]             rom_sel,
    input logic [1:0]                   mirror
);
    localparam int                PRG_BW    = $clog2(PRG_BANKS);
    localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);
    localparam logic [SEL_W-1:0]  SEL_P0    = SEL_W'(6);
    localparam logic [SEL_W-1:0]  SEL_P1    = SEL_W'(7);

    // R7
    pat_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ppu_re) |-> (ppu_rdata == 8'h00));

    // R5
    rom_re_not_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chr_rom_re |-> (rom_sel != SEL_P0 && rom_sel != SEL_P1));

    // R3
    prg_last_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_top == 3'b111) |-> (prg_bank == LAST_BANK));

    // R10
    mirror_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (mirror == 2'd0));

    // R9
    mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_we) |-> $stable(mirror));

    // R2
    wram_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_re) |-> (cpu_rdata == 8'h00));
endmodule

bind cart_bank_mapper cbm_checker #(.PRG_BANKS(PRG_BANKS), .SEL_W(SEL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_top    (cpu_addr[15:13]),
    .cpu_we     (cpu_we),
    .cpu_re     (cpu_re),
    .cpu_rdata  (cpu_rdata),
    .prg_bank   (prg_rom_addr[PRG_AW-1:13]),
    .ppu_re     (ppu_re),
    .ppu_rdata  (ppu_rdata),
    .chr_rom_re (chr_rom_re),
    .rom_sel    (chr_rom_addr[CHR_AW-1:10]),
    .mirror     (mirror)
);

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        cpu_we, cpu_re;
    logic [17:0] prg_rom_addr;
    logic [12:0] ppu_addr;
    logic [7:0]  ppu_wdata, ppu_rdata;
    logic        ppu_we, ppu_re;
    logic [18:0] chr_rom_addr;
    logic        chr_rom_re;
    logic [7:0]  chr_rom_data;
    logic [1:0]  mirror;

    always #4 clk = ~clk;

    cart_bank_mapper dut_i (.*);

    int n_chk = 0, n_fail = 0;

    function automatic int romf(int a);
        return (a * 7 + (a >> 8) * 13 + 5) & 255;
    endfunction
    function automatic int wfill(int i); return (i * 3 + 1) & 255; endfunction
    function automatic int pfill(int i); return (i * 5 + (i >> 10) * 77 + 3) & 255; endfunction

    // pattern store: data one cycle after address
    always @(posedge clk) chr_rom_data <= 8'(romf(int'(chr_rom_addr)));

    // behavioural reference model
    int m_wram [8192];
    int m_chr  [2048];
    int m_sel  [8];
    int m_prg_a, m_prg_b, m_mir, e_cpu, e_ppu;
    int t_s, t_off, t_grp, t_ri, t_slot, t_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prg_a = 0; m_prg_b = 0; m_mir = 0; e_cpu = 0; e_ppu = 0;
            foreach (m_sel[k]) m_sel[k] = 0;
        end else begin
            t_s   = m_sel[ppu_addr[12:10]];
            t_off = int'(ppu_addr[9:0]);
            if (ppu_re) e_ppu = (t_s == 6 || t_s == 7) ? m_chr[(t_s - 6) * 1024 + t_off]
                                                       : romf(t_s * 1024 + t_off);
            else        e_ppu = 0;
            if (ppu_we && (t_s == 6 || t_s == 7)) m_chr[(t_s - 6) * 1024 + t_off] = int'(ppu_wdata);
            if (cpu_re && cpu_addr >= 16'h6000 && cpu_addr < 16'h8000)
                e_cpu = m_wram[int'(cpu_addr) - 'h6000];
            else
                e_cpu = 0;
            if (cpu_we) begin
                t_d = int'(cpu_wdata);
                if (cpu_addr >= 16'h6000 && cpu_addr < 16'h8000) m_wram[int'(cpu_addr) - 'h6000] = t_d;
                else if (cpu_addr >= 16'h8000) begin
                    t_grp = int'(cpu_addr) >> 12;
                    t_ri  = (int'(cpu_addr) >> 2) & 3;
                    if (t_grp == 8) m_prg_a = t_d & 31;
                    else if (t_grp == 10) m_prg_b = t_d & 31;
                    else if (t_grp == 9) begin if (t_ri == 0) m_mir = t_d & 3; end
                    else if (t_grp >= 11 && t_grp <= 14) begin
                        t_slot = (t_grp - 11) * 2 + (t_ri >> 1);
                        if (t_ri & 1) m_sel[t_slot] = (m_sel[t_slot] & 15) | ((t_d & 31) << 4);
                        else          m_sel[t_slot] = (m_sel[t_slot] & 'h1F0) | (t_d & 15);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int b, s;
        if (!rst_n) return;
        chk("R2 cpu_rdata", cpu_rdata, e_cpu);
        chk("R7 ppu_rdata", ppu_rdata, e_ppu);
        chk("R9 mirror", mirror, m_mir);
        if (cpu_addr[15]) begin
            case (cpu_addr[14:13])
                2'd0: b = m_prg_a;
                2'd1: b = m_prg_b;
                2'd2: b = 30;
                default: b = 31;
            endcase
            chk("R3 prg_rom_addr", prg_rom_addr, b * 8192 + int'(cpu_addr[12:0]));
        end
        s = m_sel[ppu_addr[12:10]];
        chk("R6 chr_rom_addr", chr_rom_addr, s * 1024 + int'(ppu_addr[9:0]));
        chk("R5 chr_rom_re", chr_rom_re, (ppu_re && s != 6 && s != 7) ? 1 : 0);
    endtask

    task automatic idle(); cpu_we = 0; cpu_re = 0; ppu_we = 0; ppu_re = 0; endtask
    task automatic cyc(); @(negedge clk); compare_all(); endtask
    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        idle(); cpu_addr = a; cpu_wdata = d; cpu_we = 1; cyc(); idle();
    endtask
    task automatic cpu_rd(input logic [15:0] a);
        idle(); cpu_addr = a; cpu_re = 1; cyc(); idle();
    endtask
    task automatic ppu_wr(input logic [12:0] a, input logic [7:0] d);
        idle(); ppu_addr = a; ppu_wdata = d; ppu_we = 1; cyc(); idle();
    endtask
    task automatic ppu_rd(input logic [12:0] a);
        idle(); ppu_addr = a; ppu_re = 1; cyc(); idle();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        idle(); cpu_addr = 0; cpu_wdata = 0; ppu_addr = 0; ppu_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        cpu_addr = 16'h8000; ppu_addr = 13'h0000; #1;
        chk("R10 reset program bank", prg_rom_addr >> 13, 0);
        chk("R10 reset slot selector", chr_rom_addr >> 10, 0);
        chk("R10 reset mirror vertical", mirror, 0);
        chk("R10 reset ppu_rdata", ppu_rdata, 0);

        // fill work RAM and both pattern RAM pages
        cpu_wr(16'hB000, 8'd6);
        cpu_wr(16'hB008, 8'd7);
        for (int i = 0; i < 8192; i++) begin
            idle();
            cpu_addr = 16'(16'h6000 + i); cpu_wdata = 8'(wfill(i)); cpu_we = 1;
            if (i < 2048) begin
                ppu_addr = 13'(i); ppu_wdata = 8'(pfill(i)); ppu_we = 1;
            end
            cyc();
        end
        idle();

        ppu_rd(13'h0000);
        chk("R8 page 0 content", ppu_rdata, pfill(0));
        ppu_rd(13'h0400);
        chk("R8 page 1 content", ppu_rdata, pfill(1024));
        ppu_wr(13'h0010, 8'hAA);
        ppu_rd(13'h0410);
        chk("R8 page 1 untouched by page 0 write", ppu_rdata, pfill(1024 + 16));
        ppu_rd(13'h0010);
        chk("R8 page 0 write kept", ppu_rdata, 8'hAA);

        cpu_wr(16'hB000, 8'd5);
        ppu_wr(13'h0010, 8'h55);
        cpu_wr(16'hB000, 8'd6);
        ppu_rd(13'h0010);
        chk("R8 store-routed write dropped", ppu_rdata, 8'hAA);

        cpu_wr(16'hB004, 8'd1);
        ppu_addr = 13'h0000; #1;
        chk("R1 A2 selects high part of slot 0", chr_rom_addr >> 10, 9'h016);
        ppu_rd(13'h0000);
        chk("R5 selector 0x16 served by store", ppu_rdata, romf(9'h016 * 1024));
        cpu_wr(16'hB004, 8'd0);

        cpu_wr(16'hE00C, 8'h13);
        ppu_addr = 13'h1C00; #1;
        chk("R4 slot 7 high part", chr_rom_addr >> 10, 9'h130);
        cpu_wr(16'hE003, 8'h04);
        ppu_addr = 13'h1800; #1;
        chk("R1 A1/A0 ignored, slot 6 low", chr_rom_addr >> 10, 9'h004);

        cpu_wr(16'h8000, 8'd2);
        cpu_addr = 16'h8123; #1;
        chk("R3 window 8000 bank 2", prg_rom_addr, 2 * 8192 + 'h123);
        cpu_wr(16'hA00C, 8'd9);
        cpu_addr = 16'hA000; #1;
        chk("R3 window A000 bank 9", prg_rom_addr >> 13, 9);
        cpu_addr = 16'hC001; #1;
        chk("R3 window C000 fixed", prg_rom_addr >> 13, 30);
        cpu_addr = 16'hFFFF; #1;
        chk("R3 window E000 fixed", prg_rom_addr >> 13, 31);
        cpu_wr(16'h8000, 8'hE3);
        cpu_addr = 16'h8000; #1;
        chk("R3 bank value truncated", prg_rom_addr >> 13, 3);

        cpu_wr(16'h9000, 8'd1);
        chk("R9 mirror set", mirror, 1);
        cpu_wr(16'h9004, 8'd3);
        chk("R9 index 1 ignored", mirror, 1);
        cpu_wr(16'hF000, 8'hFF);

        cpu_rd(16'h6005);
        chk("R2 work RAM read", cpu_rdata, wfill(5));
        cyc();
        chk("R2 idle cpu_rdata", cpu_rdata, 0);

        for (int n = 0; n < 4000; n++) begin
            int op;
            idle();
            op = int'($urandom_range(0, 3));
            if (op == 1) begin cpu_addr = 16'(16'h6000 + $urandom_range(0, 8191)); cpu_re = 1; end
            else if (op == 2) begin
                cpu_addr = 16'(16'h6000 + $urandom_range(0, 8191));
                cpu_wdata = 8'($urandom); cpu_we = 1;
            end else if (op == 3) begin
                cpu_addr = 16'(16'h8000 | $urandom_range(0, 32767));
                cpu_wdata = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(5, 7)) : 8'($urandom);
                cpu_we = 1;
            end
            op = int'($urandom_range(0, 2));
            ppu_addr = 13'($urandom);
            if (op == 1) ppu_re = 1;
            else if (op == 2) begin ppu_wdata = 8'($urandom); ppu_we = 1; end
            cyc();
        end
        idle();
        cyc();

        summary();
        $finish;
    end
endmodule